// File: doc/BRIEF.md
# Peripheral Power-Domain Sequencer

This block switches power for up to eleven peripheral power domains. Software drives it through a small register port. It writes a per-domain gate-enable bit, then sets a bit in the power-up or the power-down trigger register. The block then runs the switch and isolation sequence for that domain. The trigger bit reads 1 while the sequence is in progress and clears itself when it ends. Sequences for different domains run side by side and do not affect each other.

Some domains sit behind a bus bridge. Each such bridge has request lines, which this block drives, and acknowledge lines, which it watches. The block enforces the order between the bridge and the switch. On power-up, a bridge request is held back until the domain's isolation has been released. On power-down, the switch sequence does not start until every acknowledge belonging to that domain has dropped.

The high-speed I/O domain has only a bridge and no switch. The USB OTG domain's power-up trigger stays pending for as long as an external PHY-reset input is held.

Top module: `pd_power_seq`

## Requirements
- R1: After reset, every switch is off, every isolation output is asserted, every bridge request is low, and every register reads 0.
- R2: The trigger registers are the up trigger at byte 0x00 and the down trigger at byte 0x04. In both, MIPI is bit 0, USB OTG is bit 2, the GPU domain is bit 7 and the display domain is bit 10. A write of 1 to any other bit is ignored.
- R3: Each domain d has a gate register at byte 0x40+4*d, with its value in bit 0. A power-up trigger is accepted only while that bit is 0, and a power-down trigger only while it is 1. A rejected trigger reads 0 and leaves the switch outputs unchanged.
- R4: An accepted trigger bit reads 1 while its sequence runs. It clears itself one cycle after the sequence ends.
- R5: On power-up, the switch turns on one cycle after the trigger write. Isolation is released SETTLE_CYC+1 cycles after that, and the trigger bit clears one cycle later.
- R6: On power-down, isolation is asserted one cycle after the trigger write. The switch turns off one cycle after that, and the trigger bit clears one cycle later.
- R7: The handshake register is at byte 0x08. Its request bits are 5 (I/O domain, lane 0), 7 (display, lane 1), and 9 and 11 (GPU, lanes 2 and 3). The acknowledge of lane i reads back at request bit + 18, that is bits 23, 25, 27 and 29.
- R8: The bridge request of a switched domain stays low until that domain's isolation has been released.
- R9: A power-down trigger for a bridged domain does not start its switch sequence while any acknowledge lane of that domain is high.
- R10: The I/O domain (bit 4) ignores trigger writes. Its bridge request follows its handshake bit directly.
- R11: While the PHY-reset input is high, the OTG power-up trigger bit does not clear. It clears one cycle after the input falls.
- R12: Triggers for several domains in one write run concurrently, each with the same timing as when run alone.
- R13: A trigger write to a domain that already has a sequence pending, in either direction, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Single-cycle register write strobe |
| addr | input | 8 | Byte address for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data |
| bridge_ack | input | 4 | Bridge acknowledge, one per lane |
| phy_rst | input | 1 | External PHY reset, holds the OTG up trigger |
| bridge_req | output | 4 | Bridge request, one per lane |
| pwr_sw_on | output | 11 | Per-domain power switch enable |
| iso_en | output | 11 | Per-domain isolation enable |

## Verification
The assertions assume that a bridge acknowledge only follows its own request line. They also assume that software writes the gate bit before the trigger that depends on it. The bench meets both conditions with a bridge model that copies each request lane onto its acknowledge half a cycle later. Every gate write in the bench completes before the trigger write that follows it. The down-ordering check is the one exception: it holds the acknowledge high by leaving the handshake request set, then clears the request to let the sequence go on.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;
  localparam int NDOM      = 11;
  localparam int NLANE     = 4;
  localparam int ACK_SHIFT = 18;
  localparam int OTG_DOM   = 2;
  localparam int HSIO_DOM  = 4;
  // domains that own a power switch: 0, 2, 7, 10
  localparam logic [NDOM-1:0] SW_DOMS = 11'h485;

  typedef enum logic [1:0] {S_IDLE, S_SETTLE, S_CUT} seq_st_t;

  // request bit of a bridge lane in the handshake register
  function automatic int lane_bit(int i);
    return 5 + 2 * i;
  endfunction

  // domain a bridge lane belongs to
  function automatic int lane_dom(int i);
    case (i)
      0:       return 4;
      1:       return 10;
      default: return 7;
    endcase
  endfunction

  function automatic logic [NLANE-1:0] dom_lanes(int d);
    logic [NLANE-1:0] m;
    for (int i = 0; i < NLANE; i++) m[i] = (lane_dom(i) == d);
    return m;
  endfunction
endpackage

// File: rtl/pd_switch_fsm.sv
module pd_switch_fsm import pd_seq_pkg::*; #(
  parameter int SETTLE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_up,
  input  logic go_dn,
  output logic sw_on,
  output logic iso,
  output logic idle
);
  localparam int CW = $clog2(SETTLE_CYC + 2);

  seq_st_t       st;
  logic [CW-1:0] cnt;
  logic          settle_done;

  function automatic logic cnt_expired(logic [CW-1:0] c);
    return c == '0;
  endfunction

  assign settle_done = (st == S_SETTLE) && cnt_expired(cnt);
  assign idle        = (st == S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      sw_on <= 1'b0;
      iso   <= 1'b1;
      cnt   <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (go_up) begin
            sw_on <= 1'b1;
            cnt   <= CW'(SETTLE_CYC);
            st    <= S_SETTLE;
          end else if (go_dn) begin
            iso <= 1'b1;
            st  <= S_CUT;
          end
        end
        S_SETTLE: begin
          if (settle_done) begin
            iso <= 1'b0;
            st  <= S_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          sw_on <= 1'b0;
          st    <= S_IDLE;
        end
      endcase
    end
  end

  AST_ISO_LEADS_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_on) |-> $past(iso)); // R6
  AST_SWITCH_LEADS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(iso) |-> (sw_on && $past(sw_on))); // R5
  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (go_up || go_dn) |-> idle); // R13
endmodule

// File: rtl/pd_domain_ctl.sv
module pd_domain_ctl #(
  parameter int SETTLE_CYC = 4,
  parameter bit IS_OTG     = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_up,
  input  logic acc_dn,
  input  logic ack_clear,
  input  logic phy_rst,
  output logic pend_up,
  output logic pend_dn,
  output logic sw_on,
  output logic iso
);
  logic launched, idle, go_up, go_dn, finish, hold;

  assign hold   = IS_OTG && phy_rst && pend_up;
  assign go_up  = pend_up && !launched && idle;
  assign go_dn  = pend_dn && !launched && idle && ack_clear;
  assign finish = launched && idle && !hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_up  <= 1'b0;
      pend_dn  <= 1'b0;
      launched <= 1'b0;
    end else begin
      if (acc_up) pend_up <= 1'b1;
      if (acc_dn) pend_dn <= 1'b1;
      if (go_up || go_dn) launched <= 1'b1;
      if (finish) begin
        pend_up  <= 1'b0;
        pend_dn  <= 1'b0;
        launched <= 1'b0;
      end
    end
  end

  pd_switch_fsm #(.SETTLE_CYC(SETTLE_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .go_up(go_up), .go_dn(go_dn),
    .sw_on(sw_on), .iso(iso), .idle(idle)
  );

  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(pend_up && pend_dn)); // R13
  AST_CUT_AFTER_BRIDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iso) |-> $past(ack_clear)); // R9
  AST_OTG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (IS_OTG && phy_rst && pend_up) |=> pend_up); // R11
  AST_UP_DONE_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_up) |-> (sw_on && !iso)); // R4
endmodule

// File: rtl/pd_power_seq.sv
module pd_power_seq import pd_seq_pkg::*; #(
  parameter int SETTLE_CYC = 4,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter logic [ADDR_W-1:0] A_UP    = 'h00,
  parameter logic [ADDR_W-1:0] A_DN    = 'h04,
  parameter logic [ADDR_W-1:0] A_HSK   = 'h08,
  parameter logic [ADDR_W-1:0] A_GATE0 = 'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [NLANE-1:0]  bridge_ack,
  input  logic              phy_rst,
  output logic [NLANE-1:0]  bridge_req,
  output logic [NDOM-1:0]   pwr_sw_on,
  output logic [NDOM-1:0]   iso_en
);
  function automatic logic [ADDR_W-1:0] gate_addr(int d);
    return A_GATE0 + ADDR_W'(4 * d);
  endfunction

  logic [NDOM-1:0]  gate, pend_up, pend_dn, acc_up, acc_dn, ack_clear, powered;
  logic [NLANE-1:0] hsk_req;
  logic             wr_up, wr_dn;
  wire              unused_wdata = ^wdata;

  assign wr_up  = wr_en && (addr == A_UP);
  assign wr_dn  = wr_en && (addr == A_DN);
  assign acc_up = {NDOM{wr_up}} & wdata[NDOM-1:0] & SW_DOMS & ~gate & ~pend_up & ~pend_dn;
  assign acc_dn = {NDOM{wr_dn}} & wdata[NDOM-1:0] & SW_DOMS &  gate & ~pend_up & ~pend_dn;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate    <= '0;
      hsk_req <= '0;
    end else if (wr_en) begin
      if (addr == A_HSK)
        for (int i = 0; i < NLANE; i++) hsk_req[i] <= wdata[lane_bit(i)];
      for (int d = 0; d < NDOM; d++)
        if (addr == gate_addr(d)) gate[d] <= wdata[0];
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_UP) rdata[NDOM-1:0] = pend_up;
    else if (addr == A_DN) rdata[NDOM-1:0] = pend_dn;
    else if (addr == A_HSK) begin
      for (int i = 0; i < NLANE; i++) begin
        rdata[lane_bit(i)]             = hsk_req[i];
        rdata[lane_bit(i) + ACK_SHIFT] = bridge_ack[i];
      end
    end else begin
      for (int d = 0; d < NDOM; d++)
        if (addr == gate_addr(d)) rdata[0] = gate[d];
    end
  end

  for (genvar d = 0; d < NDOM; d++) begin : g_dom
    assign ack_clear[d] = ~|(bridge_ack & dom_lanes(d));
    if (SW_DOMS[d]) begin : g_sw
      pd_domain_ctl #(.SETTLE_CYC(SETTLE_CYC), .IS_OTG(d == OTG_DOM)) u_ctl (
        .clk(clk), .rst_n(rst_n), .acc_up(acc_up[d]), .acc_dn(acc_dn[d]),
        .ack_clear(ack_clear[d]), .phy_rst(phy_rst),
        .pend_up(pend_up[d]), .pend_dn(pend_dn[d]),
        .sw_on(pwr_sw_on[d]), .iso(iso_en[d])
      );
      assign powered[d] = ~iso_en[d];

      AST_DOWN_NEEDS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_dn[d]) |-> $past(gate[d])); // R3
    end else begin : g_none
      assign pend_up[d]   = 1'b0;
      assign pend_dn[d]   = 1'b0;
      assign pwr_sw_on[d] = 1'b0;
      assign iso_en[d]    = 1'b1;
      assign powered[d]   = 1'b1;
    end
  end

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    assign bridge_req[i] = hsk_req[i] & powered[lane_dom(i)];
    if (SW_DOMS[lane_dom(i)]) begin : g_chk
      AST_BRIDGE_NEEDS_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
        bridge_req[i] |-> pwr_sw_on[lane_dom(i)]); // R8
    end
  end
endmodule

// File: tb/tb_pd_power_seq.sv
`timescale 1ns/10ps
module tb_pd_power_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  bridge_ack = '0;
  logic        phy_rst = 1'b0;
  logic [3:0]  bridge_req;
  logic [10:0] pwr_sw_on, iso_en;
  int          nchk = 0, nfail = 0;
  logic [31:0] v;

  always #2 clk = ~clk;

  // bridge model: acknowledge follows request half a cycle later
  always @(negedge clk) bridge_ack <= bridge_req;

  pd_power_seq dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .bridge_ack(bridge_ack), .phy_rst(phy_rst),
    .bridge_req(bridge_req), .pwr_sw_on(pwr_sw_on), .iso_en(iso_en)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #0.05;
    d = rdata;
  endtask

  task automatic wait_zero(input logic [7:0] a, input logic [31:0] m);
    logic [31:0] r;
    for (int k = 0; k < 60; k++) begin
      rd(a, r);
      if ((r & m) == 0) break;
      step(1);
    end
  endtask

  function automatic logic [7:0] ga(input int d);
    return 8'h40 + 8'(4 * d);
  endfunction

  task automatic t_reset;
    rd(8'h00, v); chk("R1 up reg", v, 0);
    rd(8'h04, v); chk("R1 down reg", v, 0);
    rd(8'h08, v); chk("R1 hsk reg", v, 0);
    rd(ga(10), v); chk("R1 gate reg", v, 0);
    chk("R1 switches", 32'(pwr_sw_on), 0);
    chk("R1 isolation", 32'(iso_en), 32'h7FF);
    chk("R1 bridge req", 32'(bridge_req), 0);
  endtask

  task automatic t_up_timing;
    wr(8'h00, 32'h1);
    rd(8'h00, v); chk("R4 up pending", v, 1);
    step(1);
    chk("R5 switch on", 32'(pwr_sw_on[0]), 1);
    chk("R5 iso held", 32'(iso_en[0]), 1);
    step(4);
    chk("R5 iso still held", 32'(iso_en[0]), 1);
    step(1);
    chk("R5 iso released", 32'(iso_en[0]), 0);
    rd(8'h00, v); chk("R4 still pending", v, 1);
    step(1);
    rd(8'h00, v); chk("R4 self cleared", v, 0);
  endtask

  task automatic t_down;
    wr(ga(0), 32'h1);
    wr(8'h04, 32'h1);
    rd(8'h04, v); chk("R4 down pending", v, 1);
    step(1);
    chk("R6 iso first", 32'({pwr_sw_on[0], iso_en[0]}), 32'h3);
    step(1);
    chk("R6 switch off", 32'({pwr_sw_on[0], iso_en[0]}), 32'h1);
    step(1);
    rd(8'h04, v); chk("R6 down cleared", v, 0);
  endtask

  task automatic t_gate;
    wr(8'h00, 32'h1);
    rd(8'h00, v); chk("R3 up rejected", v, 0);
    step(6);
    chk("R3 switch unchanged", 32'(pwr_sw_on[0]), 0);
    wr(ga(0), 32'h0);
    wr(8'h04, 32'h1);
    rd(8'h04, v); chk("R3 down rejected", v, 0);
  endtask

  task automatic t_map;
    wr(8'h00, 32'h7FF);
    rd(8'h00, v); chk("R2 accepted bits", v, 32'h485);
    wait_zero(8'h00, 32'h7FF);
    chk("R2 switches on", 32'(pwr_sw_on), 32'h485);
    chk("R10 io domain untouched", 32'(iso_en), 32'h37A);
  endtask

  task automatic t_bridge_dn;
    wr(8'h08, 32'hA00);
    step(1);
    chk("R7 gpu lanes", 32'(bridge_req), 32'hC);
    rd(8'h08, v); chk("R7 hsk readback", v, 32'h28000A00);
    wr(ga(7), 32'h1);
    wr(8'h04, 32'h80);
    step(8);
    chk("R9 waits for ack", 32'({pwr_sw_on[7], iso_en[7]}), 32'h2);
    rd(8'h04, v); chk("R9 down pending", v, 32'h80);
    wr(8'h08, 32'h0);
    wait_zero(8'h04, 32'h80);
    chk("R9 then powered down", 32'({pwr_sw_on[7], iso_en[7]}), 32'h1);
  endtask

  task automatic t_bridge_up;
    wr(ga(10), 32'h1);
    wr(8'h04, 32'h400);
    wait_zero(8'h04, 32'h400);
    wr(8'h08, 32'h80);
    step(3);
    chk("R8 req withheld", 32'(bridge_req), 0);
    wr(ga(10), 32'h0);
    wr(8'h00, 32'h400);
    wait_zero(8'h00, 32'h400);
    step(1);
    chk("R8 req released", 32'(bridge_req), 32'h2);
    rd(8'h08, v); chk("R7 display ack", v, 32'h02000080);
    wr(8'h08, 32'h0);
  endtask

  task automatic t_hsio;
    wr(8'h08, 32'h20);
    chk("R10 io req direct", 32'(bridge_req), 32'h1);
    wr(8'h00, 32'h10);
    rd(8'h00, v); chk("R10 trigger ignored", v, 0);
    chk("R10 no switch", 32'({pwr_sw_on[4], iso_en[4]}), 32'h1);
    wr(8'h08, 32'h0);
  endtask

  task automatic t_otg;
    wr(ga(2), 32'h1);
    wr(8'h04, 32'h4);
    wait_zero(8'h04, 32'h4);
    phy_rst = 1'b1;
    wr(ga(2), 32'h0);
    wr(8'h00, 32'h4);
    step(20);
    rd(8'h00, v); chk("R11 held pending", v, 32'h4);
    chk("R11 sequence ran", 32'({pwr_sw_on[2], iso_en[2]}), 32'h2);
    phy_rst = 1'b0;
    step(1);
    rd(8'h00, v); chk("R11 cleared after release", v, 0);
  endtask

  task automatic t_concurrent;
    wr(ga(0), 32'h1);
    wr(ga(2), 32'h1);
    wr(8'h04, 32'h5);
    rd(8'h04, v); chk("R12 both down pending", v, 32'h5);
    step(3);
    rd(8'h04, v); chk("R12 both down done", v, 0);
    chk("R12 both off", 32'(pwr_sw_on & 11'h5), 0);
    wr(ga(0), 32'h0);
    wr(ga(2), 32'h0);
    wr(8'h00, 32'h5);
    step(1);
    chk("R12 both switched", 32'(pwr_sw_on & 11'h5), 32'h5);
    step(5);
    chk("R12 both released", 32'(iso_en & 11'h5), 0);
    rd(8'h00, v); chk("R12 up pending", v, 32'h5);
    step(1);
    rd(8'h00, v); chk("R12 up done", v, 0);
  endtask

  task automatic t_busy;
    wr(ga(0), 32'h1);
    wr(8'h04, 32'h1);
    wr(ga(0), 32'h0);
    wr(8'h00, 32'h1);
    rd(8'h00, v); chk("R13 up while busy", v, 0);
    step(10);
    chk("R13 stays off", 32'(pwr_sw_on[0]), 0);
    rd(8'h04, v); chk("R13 down done", v, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset;
    t_up_timing;
    t_down;
    t_gate;
    t_map;
    t_bridge_dn;
    t_bridge_up;
    t_hsio;
    t_otg;
    t_concurrent;
    t_busy;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule